// File: doc/BRIEF.md
# Serial Data Link Byte Receiver with Pattern Match

This block collects the overhead bits that a line framer has already pulled out of a T1 stream. These are the data link bits in extended superframe mode, or the signalling-frame bits in superframe mode. The block packs them into bytes, one bit per qualifying strobe. The same logic serves both modes, because the framer decides which frame bit is presented. A completed byte is copied into a holding register, so the host reads a steady value while the next byte shifts in. At one link bit every 250 µs, a byte completes every 2 ms, and that is the host's window to read it.

Every completed byte is compared against two host-programmed match bytes. A buffer-full flag and a match flag each latch until the host reads status. Each flag can pull the active-low interrupt through its own enable. The host can therefore leave the link alone until a byte of interest arrives. If a byte completes while the previous one is still unread, an overrun flag is set. A bit-order parameter chooses whether the first received bit lands in the most or the least significant position.

Top module: `dl_rx_buffer`

## Requirements
- R1: After reset, `rx_byte` is 0x00, `stat_full`, `stat_match` and `stat_ovr` are 0, and `irq_n` is 1.
- R2: With the default order (MSB-first), the first bit of a byte lands in `rx_byte[7]` and the eighth bit lands in `rx_byte[0]`. With the LSB-first setting, the first bit lands in `rx_byte[0]`.
- R3: Only cycles with `bit_vld` high shift in `bit_dat`. On the clock edge that takes the eighth such bit, `rx_byte` takes the assembled byte and `stat_full` becomes 1. Fewer than eight bits leave `stat_full` untouched.
- R4: `rx_byte` holds its value while the next byte is partly received, and it changes only when a byte completes.
- R5: `stat_match` becomes 1 when a completed byte equals `match_a` or `match_b`. A completed byte that equals neither does not set it.
- R6: `irq_n` is 0 exactly when (`stat_full` and `mask_full`) or (`stat_match` and `mask_match`). A set flag whose enable is 0 leaves `irq_n` at 1.
- R7: A cycle with `rd_stat` high clears all three status flags on that edge, so `irq_n` returns to 1. If a byte completes in that same cycle, its own flags are set and `stat_ovr` stays 0.
- R8: A byte that completes while `stat_full` is still 1 and `rd_stat` is low sets `stat_ovr`.
- R9: A status flag stays at 1 over any number of cycles until `rd_stat` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | Strobe: `bit_dat` carries a link bit this cycle |
| bit_dat | input | 1 | Received link bit |
| match_a | input | 8 | First match byte |
| match_b | input | 8 | Second match byte |
| mask_full | input | 1 | Enable for the buffer-full interrupt |
| mask_match | input | 1 | Enable for the match interrupt |
| rd_stat | input | 1 | Status read strobe; clears the flags |
| rx_byte | output | 8 | Last completed byte |
| stat_full | output | 1 | Sticky buffer-full flag |
| stat_match | output | 1 | Sticky pattern-match flag |
| stat_ovr | output | 1 | Sticky overrun flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The test uses non-palindromic bytes such as 0x1B and 0x96. An MSB-first instance and an LSB-first instance take the same bit stream, so a mirrored byte or a mismatched flag shows that the bit order is wrong. Several other patterns each exercise a distinct case:
- Uneven idle gaps between strobes catch a shifter that advances without `bit_vld`.
- A byte cut off after four bits catches a holding register that is not steady, or a premature full flag.
- Hits on each match byte, and a near miss of 0x7F, tell the two comparators apart and expose a loose compare.
- Back-to-back unread bytes, a read followed by a byte, and a read on the completing cycle separate a true overrun from the read-and-refill race.

// File: rtl/dlrx_pkg.sv
package dlrx_pkg;

    typedef enum logic {
        ORDER_LSB = 1'b0,
        ORDER_MSB = 1'b1
    } bit_order_e;

    localparam int unsigned NUM_PATTERNS = 2;

endpackage

// File: rtl/dlrx_shift.sv
module dlrx_shift #(
    parameter int                   BYTE_W = 8,
    parameter dlrx_pkg::bit_order_e ORDER  = dlrx_pkg::ORDER_MSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              bit_dat,
    output logic              done,
    output logic [BYTE_W-1:0] byte_out
);
    localparam int          CW   = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic [CW-1:0]     cnt;
    } shift_state_t;

    shift_state_t st_d, st_q;
    logic [BYTE_W-1:0] shifted;

    // The parameter selects where a new bit enters the register.
    generate
        if (ORDER == dlrx_pkg::ORDER_MSB) begin : g_msb_first
            assign shifted = {st_q.sh[BYTE_W-2:0], bit_dat};
        end else begin : g_lsb_first
            assign shifted = {bit_dat, st_q.sh[BYTE_W-1:1]};
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (bit_vld) begin
            st_d.sh = shifted;
            if (st_q.cnt == LAST) begin
                st_d.cnt = '0;
                done     = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    assign byte_out = shifted;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/dlrx_match.sv
module dlrx_match #(
    parameter int BYTE_W = 8,
    parameter int N_PAT  = dlrx_pkg::NUM_PATTERNS
) (
    input  logic [N_PAT-1:0][BYTE_W-1:0] pats,
    input  logic [BYTE_W-1:0]            cand,
    output logic                         hit
);
    logic [N_PAT-1:0] eq;

    generate
        for (genvar p = 0; p < N_PAT; p++) begin : g_cmp
            assign eq[p] = (cand == pats[p]);
        end
    endgenerate

    assign hit = |eq;
endmodule

// File: rtl/dlrx_status.sv
module dlrx_status #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic              hit,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              rd_stat,
    input  logic              mask_full,
    input  logic              mask_match,
    output logic [BYTE_W-1:0] hold,
    output logic              full,
    output logic              match,
    output logic              ovr,
    output logic              irq_n
);
    typedef struct packed {
        logic [BYTE_W-1:0] hold;
        logic              full;
        logic              match;
        logic              ovr;
    } stat_state_t;

    stat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // A read clears everything first; a completing byte then sets its own flags.
        if (rd_stat) begin
            st_d.full  = 1'b0;
            st_d.match = 1'b0;
            st_d.ovr   = 1'b0;
        end
        if (done) begin
            st_d.hold = byte_in;
            st_d.full = 1'b1;
            if (st_q.full && !rd_stat) st_d.ovr = 1'b1;
            if (hit) st_d.match = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold  = st_q.hold;
    assign full  = st_q.full;
    assign match = st_q.match;
    assign ovr   = st_q.ovr;
    assign irq_n = ~((st_q.full & mask_full) | (st_q.match & mask_match));
endmodule

// File: rtl/dl_rx_buffer.sv
module dl_rx_buffer #(
    parameter int                   BYTE_W = 8,
    parameter dlrx_pkg::bit_order_e ORDER  = dlrx_pkg::ORDER_MSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              bit_dat,
    input  logic [BYTE_W-1:0] match_a,
    input  logic [BYTE_W-1:0] match_b,
    input  logic              mask_full,
    input  logic              mask_match,
    input  logic              rd_stat,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              stat_full,
    output logic              stat_match,
    output logic              stat_ovr,
    output logic              irq_n
);
    localparam int N_PAT = dlrx_pkg::NUM_PATTERNS;

    logic              done;
    logic              hit;
    logic [BYTE_W-1:0] asm_byte;
    logic [N_PAT-1:0][BYTE_W-1:0] pats;

    assign pats[0] = match_a;
    assign pats[1] = match_b;

    dlrx_shift #(.BYTE_W(BYTE_W), .ORDER(ORDER)) i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_vld  (bit_vld),
        .bit_dat  (bit_dat),
        .done     (done),
        .byte_out (asm_byte)
    );

    dlrx_match #(.BYTE_W(BYTE_W), .N_PAT(N_PAT)) i_match (
        .pats (pats),
        .cand (asm_byte),
        .hit  (hit)
    );

    dlrx_status #(.BYTE_W(BYTE_W)) i_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .done       (done),
        .hit        (hit),
        .byte_in    (asm_byte),
        .rd_stat    (rd_stat),
        .mask_full  (mask_full),
        .mask_match (mask_match),
        .hold       (rx_byte),
        .full       (stat_full),
        .match      (stat_match),
        .ovr        (stat_ovr),
        .irq_n      (irq_n)
    );
endmodule

// File: rtl/dlrx_chk.sv
module dlrx_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_vld,
    input logic              rd_stat,
    input logic              mask_full,
    input logic              mask_match,
    input logic [BYTE_W-1:0] rx_byte,
    input logic              stat_full,
    input logic              stat_match,
    input logic              stat_ovr,
    input logic              irq_n
);
    localparam int          CW   = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

    // Independent count of accepted strobes.
    logic [CW-1:0] seen_q;
    logic          cmpl;
    assign cmpl = bit_vld && (seen_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n)       seen_q <= '0;
        else if (bit_vld) seen_q <= cmpl ? '0 : seen_q + 1'b1;
    end

    assert_full_on_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl |=> stat_full);
    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cmpl |=> $stable(rx_byte));
    assert_match_only_on_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmpl && !stat_match) |=> !stat_match);
    assert_irq_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_full && mask_full) |-> !irq_n);
    assert_irq_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_match && mask_match) |-> !irq_n);
    assert_irq_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_full && !stat_match) |-> irq_n);
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !cmpl) |=> (!stat_full && !stat_match && !stat_ovr));
    assert_ovr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl && stat_full && !rd_stat) |=> stat_ovr);
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_full && !rd_stat) |=> stat_full);
endmodule

bind dl_rx_buffer dlrx_chk #(.BYTE_W(BYTE_W)) i_dlrx_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_vld    (bit_vld),
    .rd_stat    (rd_stat),
    .mask_full  (mask_full),
    .mask_match (mask_match),
    .rx_byte    (rx_byte),
    .stat_full  (stat_full),
    .stat_match (stat_match),
    .stat_ovr   (stat_ovr),
    .irq_n      (irq_n)
);

// File: tb/test_dl_rx_buffer.sv
module test_dl_rx_buffer;
    import dlrx_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic       bit_vld = 1'b0, bit_dat = 1'b0, rd_stat = 1'b0;
    logic       mask_full = 1'b0, mask_match = 1'b0;
    logic [7:0] match_a = 8'h7E, match_b = 8'h96;

    logic [7:0] m_byte, l_byte;
    logic       m_full, m_match, m_ovr, m_irq_n;
    logic       l_full, l_match, l_ovr, l_irq_n;

    dl_rx_buffer #(.BYTE_W(8), .ORDER(ORDER_MSB)) i_dl_rx_buffer (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_dat(bit_dat),
        .match_a(match_a), .match_b(match_b), .mask_full(mask_full),
        .mask_match(mask_match), .rd_stat(rd_stat), .rx_byte(m_byte),
        .stat_full(m_full), .stat_match(m_match), .stat_ovr(m_ovr), .irq_n(m_irq_n));

    dl_rx_buffer #(.BYTE_W(8), .ORDER(ORDER_LSB)) i_dl_rx_buffer_lsb (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_dat(bit_dat),
        .match_a(match_a), .match_b(match_b), .mask_full(mask_full),
        .mask_match(mask_match), .rd_stat(rd_stat), .rx_byte(l_byte),
        .stat_full(l_full), .stat_match(l_match), .stat_ovr(l_ovr), .irq_n(l_irq_n));

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [7:0] msb;
        logic [7:0] lsb;
        logic       mm;
        logic       ml;
    } exp_t;

    exp_t sb_q[$];
    event byte_done;
    logic model_mm = 1'b0, model_ml = 1'b0;

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b, input int gap);
        bit_vld = 1'b1;
        bit_dat = b;
        @(negedge clk);
        bit_vld = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    // Sends v[hi] first down to v[lo]; optionally raises rd_stat with the last bit.
    task automatic send_part(input logic [7:0] v, input int hi, input int lo, input bit rd_last);
        for (int i = hi; i >= lo; i--) begin
            if (i == lo && rd_last) rd_stat = 1'b1;
            drive_bit(v[i], (i == lo) ? 0 : (i % 3));
        end
        rd_stat = 1'b0;
    endtask

    task automatic push_expect(input logic [7:0] v, input bit rd_last);
        exp_t e;
        if (rd_last) begin
            model_mm = 1'b0;
            model_ml = 1'b0;
        end
        e.msb = v;
        e.lsb = rev8(v);
        model_mm = model_mm | (e.msb == match_a) | (e.msb == match_b);
        model_ml = model_ml | (e.lsb == match_a) | (e.lsb == match_b);
        e.mm = model_mm;
        e.ml = model_ml;
        sb_q.push_back(e);
        -> byte_done;
    endtask

    task automatic send_byte(input logic [7:0] v, input bit rd_last);
        send_part(v, 7, 0, rd_last);
        push_expect(v, rd_last);
    endtask

    task automatic read_clear();
        rd_stat = 1'b1;
        @(negedge clk);
        rd_stat = 1'b0;
        model_mm = 1'b0;
        model_ml = 1'b0;
    endtask

    // Monitor: compare each completed byte against the scoreboard.
    initial begin
        forever begin
            exp_t e;
            @(byte_done);
            e = sb_q.pop_front();
            chk("R2", "msb-first byte", 32'(m_byte), 32'(e.msb));
            chk("R2", "lsb-first byte", 32'(l_byte), 32'(e.lsb));
            chk("R3", "full after byte", 32'(m_full), 32'd1);
            chk("R3", "full after byte lsb", 32'(l_full), 32'd1);
            chk("R5", "match msb", 32'(m_match), 32'(e.mm));
            chk("R5", "match lsb", 32'(l_match), 32'(e.ml));
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "rx_byte", 32'(m_byte), 32'h00);
        chk("R1", "full", 32'(m_full), 32'd0);
        chk("R1", "match", 32'(m_match), 32'd0);
        chk("R1", "ovr", 32'(m_ovr), 32'd0);
        chk("R1", "irq_n", 32'(m_irq_n), 32'd1);

        // R2/R3 plain byte with gaps; flags masked
        send_byte(8'h1B, 1'b0);
        chk("R6", "irq masked", 32'(m_irq_n), 32'd1);
        repeat (5) @(negedge clk);
        chk("R9", "full sticky", 32'(m_full), 32'd1);
        read_clear();
        chk("R7", "full cleared", 32'(m_full), 32'd0);

        // R4 partial byte keeps previous value
        send_part(8'hC3, 7, 4, 1'b0);
        chk("R4", "hold during partial", 32'(m_byte), 32'h1B);
        chk("R3", "no full on partial", 32'(m_full), 32'd0);
        send_part(8'hC3, 3, 0, 1'b0);
        push_expect(8'hC3, 1'b0);
        read_clear();

        // R5 match on first pattern; R6 masking
        send_byte(8'h7E, 1'b0);
        chk("R6", "match masked", 32'(m_irq_n), 32'd1);
        mask_match = 1'b1;
        #1;
        chk("R6", "match enabled", 32'(m_irq_n), 32'd0);
        @(negedge clk);
        read_clear();
        chk("R7", "irq released", 32'(m_irq_n), 32'd1);
        chk("R7", "match cleared", 32'(m_match), 32'd0);

        // R5 second pattern: only msb-first instance hits
        send_byte(8'h96, 1'b0);
        chk("R6", "irq msb match", 32'(m_irq_n), 32'd0);
        chk("R6", "irq lsb none", 32'(l_irq_n), 32'd1);
        read_clear();

        // R5 near miss; R6 full interrupt
        mask_match = 1'b0;
        mask_full  = 1'b1;
        send_byte(8'h7F, 1'b0);
        chk("R6", "irq on full", 32'(m_irq_n), 32'd0);

        // R8 overrun
        send_byte(8'hFF, 1'b0);
        chk("R8", "overrun set", 32'(m_ovr), 32'd1);
        read_clear();
        chk("R7", "ovr cleared", 32'(m_ovr), 32'd0);
        send_byte(8'h55, 1'b0);
        chk("R8", "no ovr after read", 32'(m_ovr), 32'd0);

        // R7 read coinciding with completion
        send_byte(8'h81, 1'b1);
        chk("R7", "ovr on coincide", 32'(m_ovr), 32'd0);
        chk("R7", "rx on coincide", 32'(m_byte), 32'h81);

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule